// File: doc/BRIEF.md
# Coincidence-Gated Sequential Chip Readout Controller

This controller sits between a group of analogue front-end chips and the ADC they share. Every cycle it samples one discriminator line per monitored channel and stamps each hit with a free-running fine counter. On the first hit it raises a hold line that freezes the sample-and-hold stages of every chip. It then waits a programmable number of cycles for a hit on a second, different channel. If that hit does not come, it drops the hold and re-arms without reading anything.

Once two distinct channels have fired, the controller reads the chips one at a time. Only chips that own at least one hit channel are read, in ascending chip order. For each chip it steps the analogue multiplexer through every anode channel. Each channel is held for a fixed number of cycles, with a sample strobe to the ADC in the last of them. Hits that arrive while the readout runs are dropped, so the dead time grows with the number of chips read. The controller is armed again in the cycle after the last chip finishes.

Top module: `coinc_readout_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, hold_o, busy_o, adc_strobe_o, chip_done_o and ts_valid_o are low.
- R2: While busy_o is low, a cycle with hit_i nonzero produces ts_valid_o high in the next cycle, with ts_hits_o equal to that hit_i pattern and ts_o equal to the fine counter value of the hit cycle. The fine counter is 0 in the first clock after reset release, adds one every clock and wraps at 2^TDC_W.
- R3: hold_o rises in the cycle after the first hit of an idle controller and stays high until the window expires or the readout ends.
- R4: Readout starts when at least two distinct channels have been hit. Hits count from the cycle of the first hit through the win_len_i cycles after it. A channel hit more than once counts once. Two channels hit in the same cycle start the readout at once.
- R5: If the condition of R4 is not met, hold_o is low in cycle win_len_i+1 after the first hit and no strobe occurs. A hit in or after that cycle opens a new window. A win_len_i of 0 behaves as 1.
- R6: Monitored channel k belongs to chip k / HITS_PER_CHIP. Only chips with a hit channel are read, in ascending index order. While busy_o is high, chip_sel_o is one-hot with bit i selecting chip i.
- R7: For each chip read, mux_sel_o steps through 0 to CH_PER_CHIP-1 in order, holding each value for SLOT_CYC cycles. adc_strobe_o is high in the last cycle of each slot and only while busy_o is high.
- R8: chip_done_o is high together with the strobe of the last channel of each chip read, and at no other time.
- R9: busy_o rises in the cycle after the coincidence is met and stays high for exactly (chips read) x CH_PER_CHIP x SLOT_CYC cycles. hold_o is high throughout.
- R10: Hits while busy_o is high produce no timestamp and have no effect on which chips are read or on the next window.
- R11: In the cycle after the last chip_done_o, busy_o and hold_o are low and a hit in that cycle is timestamped and opens a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the fine-counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | N_CHIPS*HITS_PER_CHIP | Per-channel discriminator hits |
| win_len_i | input | WIN_W | Coincidence window length in cycles |
| hold_o | output | 1 | Hold to the front-end sample-and-hold |
| busy_o | output | 1 | Readout sequence in progress |
| ts_valid_o | output | 1 | Timestamp valid |
| ts_o | output | TDC_W | Fine counter value of the hit cycle |
| ts_hits_o | output | N_CHIPS*HITS_PER_CHIP | Hit pattern stamped |
| chip_sel_o | output | N_CHIPS | One-hot chip being read |
| mux_sel_o | output | $clog2(CH_PER_CHIP) | Anode channel multiplex select |
| adc_strobe_o | output | 1 | ADC sample strobe |
| chip_done_o | output | 1 | Last channel of a chip sampled |

## Verification
The hardest situations to reach are the edges of the coincidence window and the cycles around the end of a readout. Three cases matter: a second hit in the very last window cycle, a second hit one cycle too late, and a hit in the first cycle after the final chip completes. The stimulus reaches them by counting negative edges from the first hit or from the falling busy flag. Hits are also injected in the middle of a readout, and a single later hit then shows that those hits left no trace.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_READ = 2'd2
  } rdo_state_e;
endpackage

// File: rtl/rdo_hit_stamp.sv
module rdo_hit_stamp #(
  parameter int N_HIT = 36,
  parameter int TDC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_HIT-1:0] hit_i,
  input  logic             armed_i,
  output logic             ts_valid_o,
  output logic [TDC_W-1:0] ts_o,
  output logic [N_HIT-1:0] ts_hits_o
);
  logic [TDC_W-1:0] fine_cnt_q;
  logic             take;

  assign take = armed_i && (|hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fine_cnt_q <= '0;
    else         fine_cnt_q <= fine_cnt_q + TDC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_valid_o <= 1'b0;
      ts_o       <= '0;
      ts_hits_o  <= '0;
    end else begin
      ts_valid_o <= take;
      if (take) begin
        ts_o      <= fine_cnt_q;
        ts_hits_o <= hit_i;
      end
    end
  end

  AST_TS_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |-> (ts_hits_o != '0)); // R2
  AST_TS_ONLY_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |-> $past(armed_i)); // R10
endmodule

// File: rtl/rdo_coinc_fsm.sv
module rdo_coinc_fsm
  import rdo_pkg::*;
#(
  parameter int N_CHIPS       = 6,
  parameter int HITS_PER_CHIP = 6,
  parameter int WIN_W         = 8,
  localparam int N_HIT        = N_CHIPS * HITS_PER_CHIP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_HIT-1:0]   hit_i,
  input  logic [WIN_W-1:0]   win_len_i,
  input  logic               seq_last_i,
  output rdo_state_e         state_o,
  output logic               start_o,
  output logic [N_CHIPS-1:0] start_mask_o
);
  rdo_state_e       state_q;
  logic [N_HIT-1:0] acc_q, acc_nxt;
  logic [WIN_W-1:0] win_cnt_q;
  logic [WIN_W:0]   cnt_p1;
  logic             coinc, win_expire;

  assign acc_nxt    = acc_q | hit_i;
  assign coinc      = $countones(acc_nxt) >= 2;
  assign cnt_p1     = {1'b0, win_cnt_q} + (WIN_W+1)'(1);
  assign win_expire = cnt_p1 >= {1'b0, win_len_i};
  assign start_o    = (state_q != ST_READ) && coinc;
  assign state_o    = state_q;

  for (genvar c = 0; c < N_CHIPS; c++) begin : g_chip_mask
    assign start_mask_o[c] = |acc_nxt[c*HITS_PER_CHIP +: HITS_PER_CHIP];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      acc_q     <= '0;
      win_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (coinc) begin
            state_q <= ST_READ;
            acc_q   <= '0;
          end else if (|hit_i) begin
            state_q   <= ST_WAIT;
            acc_q     <= hit_i;
            win_cnt_q <= '0;
          end
        end
        ST_WAIT: begin
          if (coinc) begin
            state_q <= ST_READ;
            acc_q   <= '0;
          end else if (win_expire) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
          end else begin
            win_cnt_q <= win_cnt_q + WIN_W'(1);
            acc_q     <= acc_nxt;
          end
        end
        ST_READ: begin
          if (seq_last_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> ($countones(acc_q) == 1)); // R4
  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> ((win_len_i == '0) || (win_cnt_q < win_len_i))); // R5
  AST_START_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (start_mask_o != '0)); // R6
  AST_READ_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && seq_last_i) |=> (state_q == ST_IDLE)); // R11
endmodule

// File: rtl/rdo_chip_seq.sv
module rdo_chip_seq #(
  parameter int N_CHIPS     = 6,
  parameter int CH_PER_CHIP = 16,
  parameter int SLOT_CYC    = 4,
  localparam int CH_W       = $clog2(CH_PER_CHIP),
  localparam int SLOT_W     = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_CHIPS-1:0] start_mask_i,
  output logic               busy_o,
  output logic [N_CHIPS-1:0] chip_sel_o,
  output logic [CH_W-1:0]    mux_sel_o,
  output logic               adc_strobe_o,
  output logic               chip_done_o,
  output logic               last_o
);
  logic [N_CHIPS-1:0] rem_q, cur_oh, rem_after;
  logic [CH_W-1:0]    ch_q;
  logic [SLOT_W-1:0]  slot_q;
  logic               active_q, slot_end, chip_end;

  // lowest pending chip goes first
  assign cur_oh    = rem_q & (~rem_q + N_CHIPS'(1));
  assign rem_after = rem_q & ~cur_oh;
  assign slot_end  = active_q && (slot_q == SLOT_W'(SLOT_CYC-1));
  assign chip_end  = slot_end && (ch_q == CH_W'(CH_PER_CHIP-1));
  assign last_o    = chip_end && (rem_after == '0);

  assign busy_o       = active_q;
  assign chip_sel_o   = active_q ? cur_oh : '0;
  assign mux_sel_o    = ch_q;
  assign adc_strobe_o = slot_end;
  assign chip_done_o  = chip_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      ch_q     <= '0;
      slot_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rem_q    <= start_mask_i;
      ch_q     <= '0;
      slot_q   <= '0;
    end else if (active_q) begin
      if (slot_end) begin
        slot_q <= '0;
        if (chip_end) begin
          ch_q     <= '0;
          rem_q    <= rem_after;
          active_q <= (rem_after != '0);
        end else begin
          ch_q <= ch_q + CH_W'(1);
        end
      end else begin
        slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $onehot(chip_sel_o)); // R6
  AST_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_strobe_o |-> busy_o); // R7
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q); // R10
  AST_CHIP_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_done_o && !last_o) |=> (chip_sel_o > $past(chip_sel_o))); // R6
  AST_MUX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(adc_strobe_o)) |-> $stable(mux_sel_o)); // R7
  AST_DONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_done_o |-> (adc_strobe_o && mux_sel_o == CH_W'(CH_PER_CHIP-1))); // R8
endmodule

// File: rtl/coinc_readout_ctrl.sv
module coinc_readout_ctrl
  import rdo_pkg::*;
#(
  parameter int N_CHIPS       = 6,
  parameter int HITS_PER_CHIP = 6,
  parameter int CH_PER_CHIP   = 16,
  parameter int SLOT_CYC      = 4,
  parameter int TDC_W         = 16,
  parameter int WIN_W         = 8,
  localparam int N_HIT        = N_CHIPS * HITS_PER_CHIP,
  localparam int CH_W         = $clog2(CH_PER_CHIP)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_HIT-1:0]   hit_i,
  input  logic [WIN_W-1:0]   win_len_i,
  output logic               hold_o,
  output logic               busy_o,
  output logic               ts_valid_o,
  output logic [TDC_W-1:0]   ts_o,
  output logic [N_HIT-1:0]   ts_hits_o,
  output logic [N_CHIPS-1:0] chip_sel_o,
  output logic [CH_W-1:0]    mux_sel_o,
  output logic               adc_strobe_o,
  output logic               chip_done_o
);
  rdo_state_e         state;
  logic               start, seq_last, armed;
  logic [N_CHIPS-1:0] start_mask;

  assign armed  = (state != ST_READ);
  assign hold_o = (state != ST_IDLE);

  rdo_hit_stamp #(.N_HIT(N_HIT), .TDC_W(TDC_W)) u_stamp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit_i),
    .armed_i    (armed),
    .ts_valid_o (ts_valid_o),
    .ts_o       (ts_o),
    .ts_hits_o  (ts_hits_o)
  );

  rdo_coinc_fsm #(.N_CHIPS(N_CHIPS), .HITS_PER_CHIP(HITS_PER_CHIP), .WIN_W(WIN_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit_i),
    .win_len_i    (win_len_i),
    .seq_last_i   (seq_last),
    .state_o      (state),
    .start_o      (start),
    .start_mask_o (start_mask)
  );

  rdo_chip_seq #(.N_CHIPS(N_CHIPS), .CH_PER_CHIP(CH_PER_CHIP), .SLOT_CYC(SLOT_CYC)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_mask_i (start_mask),
    .busy_o       (busy_o),
    .chip_sel_o   (chip_sel_o),
    .mux_sel_o    (mux_sel_o),
    .adc_strobe_o (adc_strobe_o),
    .chip_done_o  (chip_done_o),
    .last_o       (seq_last)
  );

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> hold_o); // R9
  AST_BUSY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (state == ST_READ)); // R9
endmodule

// File: tb/coinc_readout_ctrl_tb_top.sv
module coinc_readout_ctrl_tb_top;
  localparam int NC = 6, HPC = 6, CPC = 16, SLOT = 4, TW = 16, WW = 8;
  localparam int NH = NC * HPC;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [NH-1:0] hit_i;
  logic [WW-1:0] win_len_i;
  logic          hold_o, busy_o, ts_valid_o, adc_strobe_o, chip_done_o;
  logic [TW-1:0] ts_o;
  logic [NH-1:0] ts_hits_o;
  logic [NC-1:0] chip_sel_o;
  logic [3:0]    mux_sel_o;

  always #2.5 clk = ~clk;

  coinc_readout_ctrl #(.N_CHIPS(NC), .HITS_PER_CHIP(HPC), .CH_PER_CHIP(CPC),
                       .SLOT_CYC(SLOT), .TDC_W(TW), .WIN_W(WW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hit_i(hit_i), .win_len_i(win_len_i),
    .hold_o(hold_o), .busy_o(busy_o), .ts_valid_o(ts_valid_o), .ts_o(ts_o),
    .ts_hits_o(ts_hits_o), .chip_sel_o(chip_sel_o), .mux_sel_o(mux_sel_o),
    .adc_strobe_o(adc_strobe_o), .chip_done_o(chip_done_o)
  );

  typedef struct { int chip; int ch; bit done; } strobe_t;

  int n_tests = 0, n_fail = 0;
  int cyc;
  logic [TW-1:0] ts_exp_q[$];
  logic [NH-1:0] hits_exp_q[$];
  strobe_t       strb_exp_q[$];
  int            busy_exp_q[$];
  int            busy_run = 0;

  // reference fine counter: 0 in first clock after reset, +1 per clock
  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; leaves at the next negedge
  task automatic drive_hits(input logic [NH-1:0] pat, input bit stamped);
    hit_i = pat;
    if (stamped) begin
      ts_exp_q.push_back(TW'(cyc));
      hits_exp_q.push_back(pat);
    end
    @(negedge clk);
    hit_i = '0;
  endtask

  task automatic expect_read(input logic [NC-1:0] chips);
    int n = 0;
    for (int c = 0; c < NC; c++) begin
      if (chips[c]) begin
        n++;
        for (int k = 0; k < CPC; k++) begin
          strobe_t s;
          s.chip = c; s.ch = k; s.done = (k == CPC-1);
          strb_exp_q.push_back(s);
        end
      end
    end
    busy_exp_q.push_back(n * CPC * SLOT);
  endtask

  task automatic wait_idle();
    while (hold_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [NH-1:0] ch(input int k);
    logic [NH-1:0] v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  // monitor: pops scoreboard entries as the design produces results
  always @(negedge clk) begin
    if (rst_ni) begin
      if (ts_valid_o) begin
        if (ts_exp_q.size() == 0) chk(0, "R10", "unexpected timestamp", ts_o, -1);
        else begin
          logic [TW-1:0] e_ts;
          logic [NH-1:0] e_h;
          e_ts = ts_exp_q.pop_front();
          e_h  = hits_exp_q.pop_front();
          chk(ts_o == e_ts, "R2", "timestamp", ts_o, e_ts);
          chk(ts_hits_o == e_h, "R2", "hit pattern", ts_hits_o, e_h);
        end
      end
      if (busy_o) begin
        busy_run++;
        if (!hold_o) chk(0, "R9", "hold during busy", hold_o, 1);
      end else if (busy_run > 0) begin
        if (busy_exp_q.size() == 0) chk(0, "R9", "unexpected busy", busy_run, 0);
        else begin
          int e;
          e = busy_exp_q.pop_front();
          chk(busy_run == e, "R9", "busy length", busy_run, e);
        end
        busy_run = 0;
      end
      if (adc_strobe_o) begin
        if (strb_exp_q.size() == 0) chk(0, "R5", "unexpected strobe", mux_sel_o, -1);
        else begin
          strobe_t s;
          int idx = -1;
          s = strb_exp_q.pop_front();
          for (int c = 0; c < NC; c++) if (chip_sel_o[c]) idx = c;
          chk($onehot(chip_sel_o) && idx == s.chip, "R6", "chip select", chip_sel_o, s.chip);
          chk(int'(mux_sel_o) == s.ch, "R7", "mux select", mux_sel_o, s.ch);
          chk(busy_run % SLOT == 0, "R7", "strobe slot phase", busy_run, SLOT);
          chk(chip_done_o == s.done, "R8", "chip done", chip_done_o, s.done);
        end
      end else if (chip_done_o) begin
        chk(0, "R8", "done without strobe", chip_done_o, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; hit_i = '0; win_len_i = WW'(8);
    repeat (3) @(negedge clk);
    chk(!hold_o && !busy_o && !adc_strobe_o && !ts_valid_o && !chip_done_o,
        "R1", "outputs in reset", {hold_o, busy_o, adc_strobe_o, ts_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!hold_o && !busy_o && !ts_valid_o, "R1", "outputs after reset",
        {hold_o, busy_o, ts_valid_o}, 0);

    // single hit: hold then release at cycle win+1, no readout (R3, R5)
    drive_hits(ch(3), 1);
    chk(hold_o == 1, "R3", "hold after first hit", hold_o, 1);
    repeat (7) @(negedge clk);
    chk(hold_o == 1, "R5", "hold at last window cycle", hold_o, 1);
    @(negedge clk);
    chk(hold_o == 0, "R5", "hold released after window", hold_o, 0);
    wait_idle();

    // two chips hit in same cycle (R4, R6)
    expect_read(6'b000101);
    drive_hits(ch(0) | ch(13), 1);
    chk(busy_o == 1, "R9", "busy after same-cycle pair", busy_o, 1);
    wait_idle();

    // second hit in the last window cycle (R4)
    drive_hits(ch(7), 1);
    repeat (7) @(negedge clk);
    expect_read(6'b100010);
    drive_hits(ch(30), 1);
    chk(busy_o == 1, "R4", "read on edge-of-window hit", busy_o, 1);
    wait_idle();

    // second hit one cycle too late opens a new window (R5)
    drive_hits(ch(2), 1);
    repeat (8) @(negedge clk);
    chk(hold_o == 0, "R5", "hold low before late hit", hold_o, 0);
    drive_hits(ch(4), 1);
    chk(hold_o == 1 && busy_o == 0, "R5", "late hit new window", {hold_o, busy_o}, 2);
    repeat (8) @(negedge clk);
    chk(hold_o == 0, "R5", "second window released", hold_o, 0);
    wait_idle();

    // same channel twice is one channel (R4)
    drive_hits(ch(20), 1);
    repeat (2) @(negedge clk);
    drive_hits(ch(20), 1);
    chk(busy_o == 0, "R4", "repeat channel no readout", busy_o, 0);
    repeat (5) @(negedge clk);
    chk(hold_o == 0, "R4", "repeat channel released", hold_o, 0);
    wait_idle();

    // two hits on one chip: only that chip (R6)
    expect_read(6'b000001);
    drive_hits(ch(0) | ch(1), 1);
    wait_idle();

    // hits during readout ignored, re-arm next cycle (R10, R11)
    expect_read(6'b000011);
    drive_hits(ch(1) | ch(8), 1);
    repeat (10) @(negedge clk);
    drive_hits(ch(35), 0);
    repeat (20) @(negedge clk);
    drive_hits(ch(0) | ch(12) | ch(33), 0);
    while (busy_o) @(negedge clk);
    chk(hold_o == 0, "R11", "hold low after last chip", hold_o, 0);
    drive_hits(ch(35), 1);
    chk(hold_o == 1 && busy_o == 0, "R11", "re-armed window", {hold_o, busy_o}, 2);
    repeat (8) @(negedge clk);
    chk(hold_o == 0 && busy_o == 0, "R10", "no leftover hits", {hold_o, busy_o}, 0);
    wait_idle();

    // zero window behaves as one cycle (R5)
    win_len_i = '0;
    drive_hits(ch(5), 1);
    chk(hold_o == 1, "R5", "zero window hold", hold_o, 1);
    @(negedge clk);
    chk(hold_o == 0, "R5", "zero window release", hold_o, 0);
    win_len_i = WW'(8);
    wait_idle();

    // all chips: longest dead time (R9)
    expect_read(6'b111111);
    drive_hits(ch(0) | ch(6) | ch(12) | ch(18) | ch(24) | ch(30), 1);
    wait_idle();

    repeat (4) @(negedge clk);
    chk(ts_exp_q.size() == 0, "R2", "timestamps left", ts_exp_q.size(), 0);
    chk(strb_exp_q.size() == 0, "R7", "strobes left", strb_exp_q.size(), 0);
    chk(busy_exp_q.size() == 0, "R9", "readouts left", busy_exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule